// File: doc/BRIEF.md
# Load Ordering Gate for Speculative Stores

This block sits next to a reorder buffer and decides, for each load that wants to touch memory, whether the access may go ahead now or must wait. Stores in this machine write memory only when they retire at the head of the reorder buffer. Because those writes happen in program order, write-after-write and write-after-read hazards through memory are already impossible. The one hazard left is a load that reads a location an older, still-pending store is going to write. This block catches that case.

The gate keeps one slot per reorder-buffer tag. A slot records whether a store occupies that tag, whether its address has been resolved yet, and the address itself. When a load request arrives, the gate compares it against every occupied slot that is older than the load. Age is measured by distance from the current head. The load is held back if any older store has an unknown address or the same address. The decision appears one cycle later as a grant or a block, together with the load's tag.

A blocked load is re-presented by its issue logic later. It passes once the conflicting store has retired or its address has been shown to differ. A flush empties the table and kills any request in flight.

Top module: `lso_order_check`

## Requirements
- R1: A load request in cycle t produces, in cycle t+1, exactly one of ld_grant_o or ld_block_o high, with ld_rsp_tag_o equal to the requested tag. A cycle with no request produces both outputs low in the next cycle.
- R2: A load is blocked when some older occupied store slot holds a resolved address equal to the load address.
- R3: A load is granted when every older occupied store slot holds a resolved address different from the load address.
- R4: A load is blocked when some older occupied store slot has no resolved address yet.
- R5: Age is the tag distance (tag - head_tag_i) mod DEPTH, with DEPTH = 8 tags of 3 bits by default. A store is older only if its distance is strictly smaller than the load's distance. Younger stores, including across tag wrap-around, never block. A load at distance 0 is always granted.
- R6: After a store retires (st_retire_i with its tag), its slot no longer blocks any load.
- R7: When flush_i is high in the cycle of a load request, no grant or block appears in the next cycle. A flush also empties every slot, so later loads see no stores.
- R8: During and right after reset, both ld_grant_o and ld_block_o are low and the table holds no stores.
- R9: Resolving a store address (st_addr_set_i) to a value different from a waiting load's address turns that load's decision from block to grant.
- R10: A table update in the same cycle as a load request is not seen by that request. A store retiring in the same cycle as a matching load still blocks that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard all stores and any load request in this cycle |
| head_tag_i | input | TW | Tag of the oldest reorder-buffer entry |
| st_alloc_i | input | 1 | A store takes a slot; its address is not yet known |
| st_alloc_tag_i | input | TW | Tag of the allocated store |
| st_addr_set_i | input | 1 | A store address has been resolved |
| st_addr_tag_i | input | TW | Tag of the store whose address is given |
| st_addr_i | input | AW | Resolved store address |
| st_retire_i | input | 1 | A store retires and writes memory |
| st_retire_tag_i | input | TW | Tag of the retiring store |
| ld_req_i | input | 1 | A load asks to access memory |
| ld_tag_i | input | TW | Tag of the requesting load |
| ld_addr_i | input | AW | Effective address of the load |
| ld_grant_o | output | 1 | Load may access memory (one cycle after request) |
| ld_block_o | output | 1 | Load must wait (one cycle after request) |
| ld_rsp_tag_o | output | TW | Tag the current decision belongs to |

## Verification
The bench targets the age comparison at tag wrap-around. Here a store with a numerically larger tag is older than the load, and one with a smaller tag is younger. A design that compared raw tag values would block loads on younger stores or pass loads over older ones. It also checks that a store with an unresolved address blocks the load. A design that only compared known addresses would let a load pass a store it may alias. Two more cases are a store retiring in the same cycle as a matching load, and a flush landing on a request. A wrong design would either grant too early in the first case or emit a stale decision in the second.

// File: rtl/lso_pkg.sv
package lso_pkg;

    typedef struct packed {
        logic grant;
        logic block;
    } lso_rsp_t;

endpackage

// File: rtl/lso_age_cmp.sv
module lso_age_cmp #(
    parameter int TW = 3
) (
    input  logic [TW-1:0] head,
    input  logic [TW-1:0] a_tag,
    input  logic [TW-1:0] b_tag,
    output logic          a_older
);
    logic [TW-1:0] dist_a;
    logic [TW-1:0] dist_b;

    always_comb begin
        dist_a  = a_tag - head;
        dist_b  = b_tag - head;
        a_older = (dist_a < dist_b);
    end
endmodule

// File: rtl/lso_store_table.sv
module lso_store_table #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      alloc,
    input  logic [TW-1:0]             alloc_tag,
    input  logic                      addr_set,
    input  logic [TW-1:0]             addr_tag,
    input  logic [AW-1:0]             addr_val,
    input  logic                      retire,
    input  logic [TW-1:0]             retire_tag,
    output logic [DEPTH-1:0]          busy,
    output logic [DEPTH-1:0]          known,
    output logic [DEPTH-1:0][AW-1:0]  addr
);
    typedef struct packed {
        logic [DEPTH-1:0]         busy;
        logic [DEPTH-1:0]         known;
        logic [DEPTH-1:0][AW-1:0] addr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (alloc && alloc_tag == TW'(i)) begin
                tbl_d.busy[i]  = 1'b1;
                tbl_d.known[i] = 1'b0;
            end
            if (addr_set && addr_tag == TW'(i) && tbl_d.busy[i]) begin
                tbl_d.known[i] = 1'b1;
                tbl_d.addr[i]  = addr_val;
            end
            if (retire && retire_tag == TW'(i)) begin
                tbl_d.busy[i]  = 1'b0;
                tbl_d.known[i] = 1'b0;
            end
        end
        if (flush) begin
            tbl_d.busy  = '0;
            tbl_d.known = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign busy  = tbl_q.busy;
    assign known = tbl_q.known;
    assign addr  = tbl_q.addr;
endmodule

// File: rtl/lso_hazard_scan.sv
module lso_hazard_scan #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic [TW-1:0]             head,
    input  logic [TW-1:0]             ld_tag,
    input  logic [AW-1:0]             ld_addr,
    input  logic [DEPTH-1:0]          busy,
    input  logic [DEPTH-1:0]          known,
    input  logic [DEPTH-1:0][AW-1:0]  addr,
    output logic                      conflict
);
    logic [DEPTH-1:0] older;
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        lso_age_cmp #(.TW(TW)) u_age (
            .head    (head),
            .a_tag   (TW'(g)),
            .b_tag   (ld_tag),
            .a_older (older[g])
        );
        assign hit[g] = busy[g] && older[g] && (!known[g] || addr[g] == ld_addr);
    end

    assign conflict = |hit;
endmodule

// File: rtl/lso_order_check.sv
module lso_order_check #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [TW-1:0] head_tag_i,
    input  logic          st_alloc_i,
    input  logic [TW-1:0] st_alloc_tag_i,
    input  logic          st_addr_set_i,
    input  logic [TW-1:0] st_addr_tag_i,
    input  logic [AW-1:0] st_addr_i,
    input  logic          st_retire_i,
    input  logic [TW-1:0] st_retire_tag_i,
    input  logic          ld_req_i,
    input  logic [TW-1:0] ld_tag_i,
    input  logic [AW-1:0] ld_addr_i,
    output logic          ld_grant_o,
    output logic          ld_block_o,
    output logic [TW-1:0] ld_rsp_tag_o
);
    import lso_pkg::*;

    typedef struct packed {
        lso_rsp_t      rsp;
        logic [TW-1:0] tag;
    } out_t;

    logic [DEPTH-1:0]         slot_busy;
    logic [DEPTH-1:0]         slot_known;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic                     conflict;
    out_t                     out_d, out_q;

    lso_store_table #(.DEPTH(DEPTH), .AW(AW)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush_i),
        .alloc      (st_alloc_i),
        .alloc_tag  (st_alloc_tag_i),
        .addr_set   (st_addr_set_i),
        .addr_tag   (st_addr_tag_i),
        .addr_val   (st_addr_i),
        .retire     (st_retire_i),
        .retire_tag (st_retire_tag_i),
        .busy       (slot_busy),
        .known      (slot_known),
        .addr       (slot_addr)
    );

    lso_hazard_scan #(.DEPTH(DEPTH), .AW(AW)) u_scan (
        .head     (head_tag_i),
        .ld_tag   (ld_tag_i),
        .ld_addr  (ld_addr_i),
        .busy     (slot_busy),
        .known    (slot_known),
        .addr     (slot_addr),
        .conflict (conflict)
    );

    always_comb begin
        out_d           = out_q;
        out_d.rsp.grant = ld_req_i && !flush_i && !conflict;
        out_d.rsp.block = ld_req_i && !flush_i && conflict;
        if (ld_req_i) begin
            out_d.tag = ld_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign ld_grant_o   = out_q.rsp.grant;
    assign ld_block_o   = out_q.rsp.block;
    assign ld_rsp_tag_o = out_q.tag;
endmodule

// File: rtl/lso_order_sva.sv
module lso_order_sva (
    input logic clk,
    input logic rst_n,
    input logic flush_i,
    input logic ld_req_i,
    input logic ld_grant_o,
    input logic ld_block_o
);
    assert_one_decision_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_grant_o && ld_block_o));

    assert_req_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req_i && !flush_i) |=> (ld_grant_o || ld_block_o));

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req_i |=> (!ld_grant_o && !ld_block_o));

    assert_flush_kills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!ld_grant_o && !ld_block_o));

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |=> (!ld_grant_o && !ld_block_o));
endmodule

bind lso_order_check lso_order_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .ld_req_i   (ld_req_i),
    .ld_grant_o (ld_grant_o),
    .ld_block_o (ld_block_o)
);

// File: tb/sim_lso_order_check.sv
`timescale 1ns/1ps
module sim_lso_order_check;
    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int TW    = 3;
    localparam int NVEC  = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          flush_i;
    logic [TW-1:0] head_tag_i;
    logic          st_alloc_i;
    logic [TW-1:0] st_alloc_tag_i;
    logic          st_addr_set_i;
    logic [TW-1:0] st_addr_tag_i;
    logic [AW-1:0] st_addr_i;
    logic          st_retire_i;
    logic [TW-1:0] st_retire_tag_i;
    logic          ld_req_i;
    logic [TW-1:0] ld_tag_i;
    logic [AW-1:0] ld_addr_i;
    logic          ld_grant_o;
    logic          ld_block_o;
    logic [TW-1:0] ld_rsp_tag_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lso_order_check #(.DEPTH(DEPTH), .AW(AW)) u0 (.*);

    // {head, load tag, load addr, expect block}
    // stores: tag1 @0x0040, tag3 @0x0080, tag5 unresolved
    localparam logic [TW+TW+AW:0] VEC [NVEC] = '{
        {3'd0, 3'd2, 16'h0040, 1'b1},  // R2 older match
        {3'd0, 3'd2, 16'h0080, 1'b0},  // R3 / R5 tag3 younger
        {3'd0, 3'd4, 16'h0080, 1'b1},  // R2 tag3 older match
        {3'd0, 3'd4, 16'h0044, 1'b0},  // R3 all differ
        {3'd0, 3'd6, 16'h0044, 1'b1},  // R4 tag5 unresolved
        {3'd0, 3'd0, 16'h0040, 1'b0},  // R5 load at head
        {3'd4, 3'd2, 16'h0044, 1'b1},  // R4 wrap: tag5 older
        {3'd6, 3'd2, 16'h0080, 1'b0},  // R5 wrap: tag3 and tag5 younger
        {3'd6, 3'd4, 16'h0080, 1'b1},  // R2 wrap: tag3 older
        {3'd2, 3'd2, 16'h0040, 1'b0}   // R5 distance zero
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [TW-1:0] tag, input logic [AW-1:0] a,
                         input bit exp_blk, input string req);
        @(negedge clk);
        ld_req_i  = 1'b1;
        ld_tag_i  = tag;
        ld_addr_i = a;
        @(negedge clk);
        ld_req_i = 1'b0;
        chk({ld_grant_o, ld_block_o, ld_rsp_tag_o} == {~exp_blk, exp_blk, tag}, req,
            {ld_grant_o, ld_block_o, ld_rsp_tag_o}, {~exp_blk, exp_blk, tag});
    endtask

    task automatic do_alloc(input logic [TW-1:0] tag);
        @(negedge clk);
        st_alloc_i = 1'b1; st_alloc_tag_i = tag;
        @(negedge clk);
        st_alloc_i = 1'b0;
    endtask

    task automatic do_addr(input logic [TW-1:0] tag, input logic [AW-1:0] a);
        @(negedge clk);
        st_addr_set_i = 1'b1; st_addr_tag_i = tag; st_addr_i = a;
        @(negedge clk);
        st_addr_set_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flush_i = 1'b0; head_tag_i = '0;
        st_alloc_i = 1'b0; st_alloc_tag_i = '0;
        st_addr_set_i = 1'b0; st_addr_tag_i = '0; st_addr_i = '0;
        st_retire_i = 1'b0; st_retire_tag_i = '0;
        ld_req_i = 1'b0; ld_tag_i = '0; ld_addr_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ld_grant_o == 1'b0 && ld_block_o == 1'b0, "R8 reset outputs",
            {ld_grant_o, ld_block_o}, 0);
        rst_n = 1'b1;
        probe(3'd7, 16'h0040, 1'b0, "R8 empty table grants");

        do_alloc(3'd1);
        do_alloc(3'd3);
        do_alloc(3'd5);
        do_addr(3'd1, 16'h0040);
        do_addr(3'd3, 16'h0080);
        @(negedge clk);
        chk(ld_grant_o == 1'b0 && ld_block_o == 1'b0, "R1 idle no decision",
            {ld_grant_o, ld_block_o}, 0);

        for (int i = 0; i < NVEC; i++) begin
            head_tag_i = VEC[i][TW+TW+AW:TW+AW+1];
            probe(VEC[i][TW+AW:AW+1], VEC[i][AW:1], VEC[i][0], $sformatf("R2-5 vec%0d", i));
        end

        head_tag_i = 3'd0;
        // R9: resolve tag5 away from the waiting load's address
        probe(3'd6, 16'h0044, 1'b1, "R4 before resolve");
        do_addr(3'd5, 16'h0100);
        probe(3'd6, 16'h0044, 1'b0, "R9 resolved unblocks");

        // R10: retire in the same cycle as a matching load
        @(negedge clk);
        ld_req_i = 1'b1; ld_tag_i = 3'd2; ld_addr_i = 16'h0040;
        st_retire_i = 1'b1; st_retire_tag_i = 3'd1;
        @(negedge clk);
        ld_req_i = 1'b0; st_retire_i = 1'b0;
        chk(ld_block_o == 1'b1 && ld_grant_o == 1'b0, "R10 same-cycle retire",
            {ld_grant_o, ld_block_o}, 1);
        probe(3'd2, 16'h0040, 1'b0, "R6 retired store frees");

        // R7: flush during request
        @(negedge clk);
        ld_req_i = 1'b1; ld_tag_i = 3'd4; ld_addr_i = 16'h0080; flush_i = 1'b1;
        @(negedge clk);
        ld_req_i = 1'b0; flush_i = 1'b0;
        chk(ld_grant_o == 1'b0 && ld_block_o == 1'b0, "R7 flush kills request",
            {ld_grant_o, ld_block_o}, 0);
        probe(3'd4, 16'h0080, 1'b0, "R7 flush empties table");
        probe(3'd6, 16'h0100, 1'b0, "R7 flush cleared tag5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule